// File: doc/BRIEF.md
# Single-Owner DMA Bus Arbiter

This block decides which of several devices may run direct memory transfers on the shared memory bus. It hands the bus to one device at a time and raises a bus-busy line for as long as that device owns it. Any other device that asks while the line is high waits. Arbitration runs on the rising clock edge. Data beats are launched on the falling edge, so they never compete with processor accesses, which use the rising edge.

While it owns the bus, a device gets at most one 32-bit beat per device clock period. The device clock is a tick that the block derives from the system clock. `CLK_HZ / DEV_HZ` gives the number of system clocks per tick, so a 100 kHz device rate can be set for any system clock. For each beat the block presents the owner's write word, the owner's index and a zero-based beat number. When the owner finishes it pulses its done input. The bus is then released, and one idle cycle passes before the next device can be granted.

Top module: `dma_bus_arbiter`

## Requirements
- R1: While reset is high and on the first cycle after it, `dev_grant` is all zeros and `bus_busy` and `beat_vld` are 0.
- R2: `dev_grant` never has more than one bit set, and `bus_busy` is 1 exactly when one grant bit is set.
- R3: When the bus is idle and one or more bits of `dev_req` are high at a rising edge, the grant after that edge goes to the lowest requesting index (bit i of `dev_grant` for device i), and `bus_busy` rises at that same edge.
- R4: While the bus is owned and the owner has not signalled done, `dev_grant` does not change, whatever the other devices request.
- R5: When the owner's `dev_done` bit is high at a rising edge, `bus_busy` and `dev_grant` are cleared at that edge. A new grant appears no earlier than the following rising edge, and appears there if a request is pending.
- R6: A request that is removed before it has been granted never produces a grant.
- R7: Beats are launched on the falling clock edge and only while the bus is owned. Each `beat_vld` pulse lasts one clock, and successive beats of one ownership are exactly `CLK_HZ/DEV_HZ` clocks apart.
- R8: On each beat, `beat_owner` is the owner's index and `beat_data` is the owner's word, taken from `dev_wdata[i*32 +: 32]`. `beat_count` starts at 0 for the first beat of each ownership and increases by one per beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; rising edge arbitrates, falling edge launches beats |
| rst | input | 1 | Synchronous active-high reset |
| dev_req | input | NUM_DEV | Per-device ownership request |
| dev_done | input | NUM_DEV | Per-device end-of-transfer pulse (owner's bit is used) |
| dev_wdata | input | NUM_DEV*DATA_W | Per-device write word, device i in bits i*DATA_W upward |
| dev_grant | output | NUM_DEV | One-hot ownership grant |
| bus_busy | output | 1 | High while some device owns the bus |
| dev_tick | output | 1 | One-clock pulse per device clock period |
| beat_vld | output | 1 | A beat is on the bus this cycle |
| beat_owner | output | IDX_W | Index of the device whose beat this is |
| beat_data | output | DATA_W | Beat payload |
| beat_count | output | CNT_W | Zero-based beat number within the current ownership |

## Verification
Several rules are checked by assertions at every rising edge: the grant is one-hot or empty, busy agrees with the grant, the grant holds until the owner signals done, done releases the bus on the next edge, an idle bus with requests is granted on the next edge, and every beat belongs to the current owner. The ordering across ownerships can only be shown by the bench scenarios. These cover lowest-index priority among simultaneous requests, the one idle cycle between owners, a withdrawn request that never turns into a grant, and the exact payload, index and spacing of each beat as a scoreboard receives them in sequence.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic {
    ARB_IDLE  = 1'b0,
    ARB_OWNED = 1'b1
  } arb_state_e;
endpackage

// File: rtl/dma_tick_gen.sv
module dma_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int NUM_DEV = 4,
  parameter int IDX_W   = 2
) (
  input  logic [NUM_DEV-1:0] req,
  output logic               any,
  output logic [NUM_DEV-1:0] onehot,
  output logic [IDX_W-1:0]   idx
);
  // lower index has precedence: mask off every bit above the first one found
  logic [NUM_DEV:0] seen;

  assign seen[0] = 1'b0;

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_chain
    assign onehot[g]  = req[g] & ~seen[g];
    assign seen[g+1]  = seen[g] | req[g];
  end

  assign any = seen[NUM_DEV];

  always_comb begin
    idx = '0;
    for (int i = NUM_DEV - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/dma_own_ctrl.sv
module dma_own_ctrl
  import dma_arb_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pick_any,
  input  logic [NUM_DEV-1:0] pick_onehot,
  input  logic [IDX_W-1:0]   pick_idx,
  input  logic [NUM_DEV-1:0] done,
  output logic [NUM_DEV-1:0] grant,
  output logic [IDX_W-1:0]   owner,
  output logic               busy
);
  arb_state_e state;
  logic       owner_done;

  assign owner_done = |(done & grant);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ARB_IDLE;
      grant <= '0;
      owner <= '0;
      busy  <= 1'b0;
    end else begin
      case (state)
        ARB_IDLE: begin
          if (pick_any) begin
            state <= ARB_OWNED;
            grant <= pick_onehot;
            owner <= pick_idx;
            busy  <= 1'b1;
          end
        end
        ARB_OWNED: begin
          if (owner_done) begin
            state <= ARB_IDLE;
            grant <= '0;
            busy  <= 1'b0;
          end
        end
        default: begin
          state <= ARB_IDLE;
          grant <= '0;
          busy  <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/dma_beat_engine.sv
module dma_beat_engine #(
  parameter int NUM_DEV = 4,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 2,
  parameter int CNT_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      busy,
  input  logic                      tick,
  input  logic [IDX_W-1:0]          owner,
  input  logic [NUM_DEV*DATA_W-1:0] wdata_flat,
  output logic                      beat_vld,
  output logic [IDX_W-1:0]          beat_owner,
  output logic [DATA_W-1:0]         beat_data,
  output logic [CNT_W-1:0]          beat_count
);
  logic [DATA_W-1:0] words [NUM_DEV];
  logic [CNT_W-1:0]  sent;

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_unpack
    assign words[g] = wdata_flat[g*DATA_W +: DATA_W];
  end

  // falling edge: opposite to the edge used by arbitration and the processor
  always_ff @(negedge clk) begin
    if (rst || !busy) begin
      beat_vld   <= 1'b0;
      sent       <= '0;
      beat_owner <= '0;
      beat_data  <= '0;
      beat_count <= '0;
    end else if (tick) begin
      beat_vld   <= 1'b1;
      beat_owner <= owner;
      beat_data  <= words[owner];
      beat_count <= sent;
      sent       <= sent + 1'b1;
    end else begin
      beat_vld   <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter #(
  parameter int NUM_DEV = 4,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 8,
  parameter int CLK_HZ  = 100_000_000,
  parameter int DEV_HZ  = 100_000,
  localparam int IDX_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  localparam int DIV    = CLK_HZ / DEV_HZ
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_DEV-1:0]        dev_req,
  input  logic [NUM_DEV-1:0]        dev_done,
  input  logic [NUM_DEV*DATA_W-1:0] dev_wdata,
  output logic [NUM_DEV-1:0]        dev_grant,
  output logic                      bus_busy,
  output logic                      dev_tick,
  output logic                      beat_vld,
  output logic [IDX_W-1:0]          beat_owner,
  output logic [DATA_W-1:0]         beat_data,
  output logic [CNT_W-1:0]          beat_count
);
  logic               pick_any;
  logic [NUM_DEV-1:0] pick_onehot;
  logic [IDX_W-1:0]   pick_idx;
  logic [IDX_W-1:0]   owner;

  dma_tick_gen #(.DIV(DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(dev_tick)
  );

  dma_prio_pick #(.NUM_DEV(NUM_DEV), .IDX_W(IDX_W)) u_pick (
    .req   (dev_req),
    .any   (pick_any),
    .onehot(pick_onehot),
    .idx   (pick_idx)
  );

  dma_own_ctrl #(.NUM_DEV(NUM_DEV), .IDX_W(IDX_W)) u_own (
    .clk        (clk),
    .rst        (rst),
    .pick_any   (pick_any),
    .pick_onehot(pick_onehot),
    .pick_idx   (pick_idx),
    .done       (dev_done),
    .grant      (dev_grant),
    .owner      (owner),
    .busy       (bus_busy)
  );

  dma_beat_engine #(
    .NUM_DEV(NUM_DEV), .DATA_W(DATA_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_beat (
    .clk       (clk),
    .rst       (rst),
    .busy      (bus_busy),
    .tick      (dev_tick),
    .owner     (owner),
    .wdata_flat(dev_wdata),
    .beat_vld  (beat_vld),
    .beat_owner(beat_owner),
    .beat_data (beat_data),
    .beat_count(beat_count)
  );
endmodule

// File: rtl/dma_bus_arbiter_chk.sv
module dma_bus_arbiter_chk #(
  parameter int NUM_DEV = 4,
  parameter int IDX_W   = 2
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_DEV-1:0] dev_req,
  input logic [NUM_DEV-1:0] dev_done,
  input logic [NUM_DEV-1:0] dev_grant,
  input logic               bus_busy,
  input logic               beat_vld,
  input logic [IDX_W-1:0]   beat_owner
);
  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dev_grant) && (bus_busy == (dev_grant != '0)));

  // R3
  idle_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_busy && (dev_req != '0)) |=> bus_busy);

  // R4
  hold_owner_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_busy && ((dev_done & dev_grant) == '0)) |=> $stable(dev_grant));

  // R5
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_busy && ((dev_done & dev_grant) != '0)) |=> (!bus_busy && dev_grant == '0));

  // R7
  beat_busy_chk: assert property (@(posedge clk) disable iff (rst)
    beat_vld |-> bus_busy);

  // R8
  beat_owner_chk: assert property (@(posedge clk) disable iff (rst)
    beat_vld |-> dev_grant[beat_owner]);
endmodule

bind dma_bus_arbiter dma_bus_arbiter_chk #(.NUM_DEV(NUM_DEV), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .dev_req   (dev_req),
  .dev_done  (dev_done),
  .dev_grant (dev_grant),
  .bus_busy  (bus_busy),
  .beat_vld  (beat_vld),
  .beat_owner(beat_owner)
);

// File: tb/sim_dma_bus_arbiter.sv
module sim_dma_bus_arbiter;
  localparam int ND  = 4;
  localparam int DW  = 32;
  localparam int CW  = 8;
  localparam int IW  = 2;
  localparam int DIV = 4;
  localparam int NB  = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic [ND-1:0] dev_req;
  logic [ND-1:0] dev_done;
  logic [ND*DW-1:0] dev_wdata;
  logic [ND-1:0] dev_grant;
  logic          bus_busy, dev_tick, beat_vld;
  logic [IW-1:0] beat_owner;
  logic [DW-1:0] beat_data;
  logic [CW-1:0] beat_count;

  int req_seq[ND], done_seq[ND], cancel_seq[ND], seen[ND];
  logic [ND-1:0] done_r;
  int q_own[$], q_idx[$];
  int d_cmp, d_bad, m_cmp, m_bad, w_bad;
  int beats_total, grant2_seen;
  bit finished;

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < ND; i++) dev_req[i] = (req_seq[i] != done_seq[i] + cancel_seq[i]);
    dev_done = done_r;
    for (int i = 0; i < ND; i++) dev_wdata[i*DW +: DW] = {8'(i), 24'(seen[i])};
  end

  dma_bus_arbiter #(.NUM_DEV(ND), .DATA_W(DW), .CNT_W(CW), .CLK_HZ(400_000), .DEV_HZ(100_000)) u0 (
    .clk(clk), .rst(rst), .dev_req(dev_req), .dev_done(dev_done), .dev_wdata(dev_wdata),
    .dev_grant(dev_grant), .bus_busy(bus_busy), .dev_tick(dev_tick), .beat_vld(beat_vld),
    .beat_owner(beat_owner), .beat_data(beat_data), .beat_count(beat_count)
  );

  task automatic chk(input string tag, input longint act, input longint exp, ref int c, ref int b);
    c++;
    if (act != exp) begin
      b++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push_owner(input int o);
    for (int k = 0; k < NB; k++) begin
      q_own.push_back(o);
      q_idx.push_back(k);
    end
  endtask

  task automatic sample();
    @(negedge clk); #3;
  endtask

  task automatic wait_fall();
    do sample(); while (bus_busy);
  endtask

  // device model: counts its beats, raises done after NB beats
  initial begin
    done_r = '0;
    for (int i = 0; i < ND; i++) begin
      req_seq[i] = 0; done_seq[i] = 0; cancel_seq[i] = 0; seen[i] = 0;
    end
    forever begin
      @(negedge clk); #1;
      done_r = '0;
      if (!rst && beat_vld) begin
        seen[beat_owner]++;
        if (seen[beat_owner] == NB) begin
          seen[beat_owner] = 0;
          done_r[beat_owner] = 1'b1;
          done_seq[beat_owner]++;
        end
      end
    end
  end

  // monitor / scoreboard
  initial begin
    bit prev_done, prev_beat_busy;
    int gap;
    prev_done = 0; gap = -1; prev_beat_busy = 0;
    forever begin
      sample();
      if (!rst) begin
        if (prev_done) chk("R5 busy clears after done", bus_busy, 0, m_cmp, m_bad);
        if (dev_grant[2]) grant2_seen++;
        if (gap >= 0) gap++;
        if (beat_vld) begin
          beats_total++;
          chk("R7 beat only while busy", bus_busy, 1, m_cmp, m_bad);
          if (gap > 0) chk("R7 beat spacing", gap, DIV, m_cmp, m_bad);
          gap = 0;
          if (q_own.size() == 0) begin
            m_cmp++; m_bad++;
            $display("FAIL R8 unexpected beat actual owner=%0d expected none", beat_owner);
          end else begin
            int eo, ek;
            eo = q_own.pop_front(); ek = q_idx.pop_front();
            chk("R8 beat owner", beat_owner, eo, m_cmp, m_bad);
            chk("R8 beat count", beat_count, ek, m_cmp, m_bad);
            chk("R8 beat data", beat_data, {8'(eo), 24'(ek)}, m_cmp, m_bad);
          end
        end
        if (!bus_busy) gap = -1;
        prev_done = bus_busy && ((dev_done & dev_grant) != '0);
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      w_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", d_cmp + m_cmp + 1, d_bad + m_bad + w_bad);
      $finish;
    end
  end

  // driver
  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    sample();
    chk("R1 grant in reset", dev_grant, 0, d_cmp, d_bad);
    chk("R1 busy in reset", bus_busy, 0, d_cmp, d_bad);
    chk("R1 beat in reset", beat_vld, 0, d_cmp, d_bad);
    @(posedge clk); #3 rst = 1'b0;
    sample();
    chk("R1 grant after reset", dev_grant, 0, d_cmp, d_bad);

    // simultaneous requests from 1 and 3: device 1 wins
    @(posedge clk); #3;
    req_seq[1]++; req_seq[3]++;
    push_owner(1);
    sample();
    chk("R3 no grant before edge", dev_grant, 0, d_cmp, d_bad);
    sample();
    chk("R3 lowest index granted", dev_grant, 4'b0010, d_cmp, d_bad);
    chk("R3 busy with grant", bus_busy, 1, d_cmp, d_bad);

    // device 0 arrives while 1 owns; device 2 asks and withdraws
    @(posedge clk); #3;
    req_seq[0]++; req_seq[2]++;
    push_owner(0); push_owner(3);
    sample(); sample();
    chk("R4 owner held against lower index", dev_grant, 4'b0010, d_cmp, d_bad);
    @(posedge clk); #3;
    cancel_seq[2]++;

    wait_fall();
    chk("R5 idle cycle between owners", dev_grant, 0, d_cmp, d_bad);
    sample();
    chk("R5 next grant to device 0", dev_grant, 4'b0001, d_cmp, d_bad);

    wait_fall();
    chk("R5 idle cycle before device 3", dev_grant, 0, d_cmp, d_bad);
    sample();
    chk("R5 next grant to device 3", dev_grant, 4'b1000, d_cmp, d_bad);

    wait_fall();
    for (int s = 0; s < 6; s++) begin
      sample();
      chk("R6 withdrawn request not granted", dev_grant, 0, d_cmp, d_bad);
    end
    chk("R6 device 2 never granted", grant2_seen, 0, d_cmp, d_bad);
    chk("R2 busy low with no grant", bus_busy, 0, d_cmp, d_bad);
    chk("R8 all expected beats seen", q_own.size(), 0, d_cmp, d_bad);
    chk("R7 total beats", beats_total, 3 * NB, d_cmp, d_bad);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", d_cmp + m_cmp, d_bad + m_bad + w_bad);
    $finish;
  end
endmodule